// File: doc/BRIEF.md
# Sixteen-Bit Multicycle Processor Core

This block is a small processor that runs a compact 16-bit instruction set, one instruction at a time. Its data and instructions share one word-addressed memory of up to 65536 words. That memory is reached through a single synchronous port: address, write data and write enable go out, and the read data comes back on the clock edge that follows. Architectural state is sixteen 16-bit general registers and a 16-bit program counter.

There are three instruction classes. A move loads or stores one register. Its memory operand selects one of three addressing modes: register-relative with a signed displacement, the same with an increment of the base register afterwards, or a 9-bit absolute address. An ALU instruction combines two registers into a third. A compare-and-branch adds a signed offset to the program counter when one register is, unsigned, at least another. Each instruction first advances the program counter and only then acts.

A combinational debug read port lets a testbench observe any register or the program counter without disturbing execution. A program ends by branching to itself.

Top module: `mc16_core`

## Requirements
- R1: While reset is asserted and once it is released, the program counter and all sixteen registers read zero, no memory write is issued, and the first fetch is from address 0.
- R2: The program counter is advanced by one during the decode cycle of every instruction, and a branch offset is added to this already advanced value.
- R3: Bits 15:14 = 10 select an ALU operation with source 1 in bits 13:10, source 2 in bits 9:6, destination in bits 5:2 and opcode in bits 1:0. Opcode 00 is AND, 10 is ADD and 01 is source 1 minus source 2, both wrapping modulo 2^16.
- R4: ALU opcode 11 shifts source 1 left logically by the value of bits 3:0 of source 2.
- R5: Bit 15 = 0 selects a move: bit 14 = 1 loads the register in bits 13:10 from memory, bit 14 = 0 stores it to memory, and bits 9:0 form the memory operand.
- R6: Operand bit 9 = 0 selects register-relative addressing: the base register is in bits 8:5 and a signed 4-bit displacement is in bits 4:1, giving an address of base plus displacement. When bit 0 = 0, the base register is left unchanged.
- R7: When operand bit 0 = 1 in register-relative mode, the base register is incremented by one after the access. For a load whose destination is also its base, the final value is the old base plus one.
- R8: Operand bit 9 = 1 selects absolute addressing with bits 8:0 as an unsigned address.
- R9: Bits 15:14 = 11 select a branch on register A (bits 13:10) and register B (bits 9:6). When A >= B, compared unsigned, the sign-extended offset in bits 5:0 is added to the program counter; otherwise the program counter is unchanged.
- R10: Fetch, decode and execute take one cycle each. ALU, branch and store instructions take 3 cycles, and a load takes 4 because of its extra write-back cycle.
- R11: The debug port returns register dbg_sel_i[3:0] when dbg_sel_i[4] = 0, and the program counter when dbg_sel_i[4] = 1, in the same cycle.
- R12: The memory write enable is raised only in the execute cycle of a store, carrying the stored register and the effective address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| mem_addr_o | output | 16 | Memory word address for fetch, load or store |
| mem_wdata_o | output | 16 | Store data |
| mem_we_o | output | 1 | Memory write enable |
| mem_rdata_i | input | 16 | Read data, valid the cycle after the address |
| dbg_sel_i | input | 5 | Debug select: 0-15 register, bit 4 set for program counter |
| dbg_data_o | output | 16 | Debug read data |

## Verification
The program counter steps one clock after the fetch cycle. A register written by an ALU instruction is updated at the end of its third cycle, and a loaded register at the end of its fourth; a branch moves the program counter one cycle after its decode. The timing test samples the program counter through the debug port on every falling edge and checks the gaps between changes: 3, 3, 4, 3, then 1 and 2 for a self-branch. All other programs end in a self-branch, and they are run for more cycles than their worst-case length before the registers and memory are read. By then nothing can change any longer, so these checks do not depend on which phase of the loop they sample.

// File: rtl/mc16_pkg.sv
package mc16_pkg;

  typedef enum logic [1:0] {
    ST_FETCH  = 2'd0,
    ST_DECODE = 2'd1,
    ST_EXEC   = 2'd2,
    ST_WBACK  = 2'd3
  } state_e;

  typedef enum logic [1:0] {
    ALU_AND = 2'b00,
    ALU_SUB = 2'b01,
    ALU_ADD = 2'b10,
    ALU_SHL = 2'b11
  } aluop_e;

  localparam logic [1:0] CLS_ALU = 2'b10;
  localparam logic [1:0] CLS_BR  = 2'b11;

endpackage

// File: rtl/mc16_rst_sync.sv
module mc16_rst_sync (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_no
);
  logic [1:0] sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= 2'b00;
    else         sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_no = sync_q[1];
endmodule

// File: rtl/mc16_alu.sv
module mc16_alu
  import mc16_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic [DW-1:0] a_i,
  input  logic [DW-1:0] b_i,
  input  aluop_e        op_i,
  output logic [DW-1:0] y_o
);
  localparam int SW = $clog2(DW);

  always_comb begin
    unique case (op_i)
      ALU_AND: y_o = a_i & b_i;
      ALU_ADD: y_o = a_i + b_i;
      ALU_SUB: y_o = a_i - b_i;
      default: y_o = a_i << b_i[SW-1:0];
    endcase
  end
endmodule

// File: rtl/mc16_regfile.sv
module mc16_regfile #(
  parameter int DW    = 16,
  parameter int NREGS = 16,
  localparam int AW   = $clog2(NREGS)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [AW-1:0] ra_i,
  input  logic [AW-1:0] rb_i,
  input  logic [AW-1:0] rc_i,
  input  logic [AW-1:0] rdbg_i,
  output logic [DW-1:0] a_o,
  output logic [DW-1:0] b_o,
  output logic [DW-1:0] c_o,
  output logic [DW-1:0] dbg_o,
  input  logic          we0_i,
  input  logic [AW-1:0] wa0_i,
  input  logic [DW-1:0] wd0_i,
  input  logic          we1_i,
  input  logic [AW-1:0] wa1_i,
  input  logic [DW-1:0] wd1_i
);
  logic [DW-1:0] regs [NREGS];

  for (genvar g = 0; g < NREGS; g++) begin : g_reg
    logic          hit0, hit1, en;
    logic [DW-1:0] d, q;

    assign hit0 = we0_i && (wa0_i == AW'(g));
    assign hit1 = we1_i && (wa1_i == AW'(g));
    assign en   = hit0 || hit1;

    always_comb begin
      d = wd0_i;
      if (hit1) d = wd1_i;   // second port wins (post-increment over load data)
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)  q <= '0;
      else if (en)  q <= d;
    end

    assign regs[g] = q;
  end

  assign a_o   = regs[ra_i];
  assign b_o   = regs[rb_i];
  assign c_o   = regs[rc_i];
  assign dbg_o = regs[rdbg_i];
endmodule

// File: rtl/mc16_ctrl.sv
module mc16_ctrl
  import mc16_pkg::*;
#(
  parameter int DW = 16,
  localparam int RW = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [DW-1:0] mem_rdata_i,
  input  logic [DW-1:0] src_a_i,
  input  logic [DW-1:0] src_b_i,
  input  logic [DW-1:0] base_i,
  input  logic [DW-1:0] alu_y_i,
  output state_e        state_o,
  output logic [DW-1:0] pc_o,
  output logic [DW-1:0] ir_o,
  output logic [DW-1:0] mem_addr_o,
  output logic [DW-1:0] mem_wdata_o,
  output logic          mem_we_o,
  output logic [RW-1:0] ra_o,
  output logic [RW-1:0] rb_o,
  output logic [RW-1:0] rbase_o,
  output logic          we0_o,
  output logic [RW-1:0] wa0_o,
  output logic [DW-1:0] wd0_o,
  output logic          we1_o,
  output logic [RW-1:0] wa1_o,
  output logic [DW-1:0] wd1_o
);
  state_e        state_q, state_d;
  logic [DW-1:0] pc_q, pc_d, ir_q;
  logic          pc_en, ir_en;

  logic          is_mem, is_load, is_alu, is_br, is_abs, post_inc, taken;
  logic [DW-1:0] eff_addr, br_off, disp;

  assign is_mem   = ~ir_q[15];
  assign is_load  = is_mem & ir_q[14];
  assign is_alu   = (ir_q[15:14] == CLS_ALU);
  assign is_br    = (ir_q[15:14] == CLS_BR);
  assign is_abs   = ir_q[9];
  assign post_inc = ~ir_q[9] & ir_q[0];
  assign disp     = {{(DW-4){ir_q[4]}}, ir_q[4:1]};
  assign eff_addr = is_abs ? {{(DW-9){1'b0}}, ir_q[8:0]} : base_i + disp;
  assign br_off   = {{(DW-6){ir_q[5]}}, ir_q[5:0]};
  assign taken    = (src_a_i >= src_b_i);

  assign ra_o    = ir_q[13:10];
  assign rb_o    = ir_q[9:6];
  assign rbase_o = ir_q[8:5];

  always_comb begin
    state_d     = state_q;
    pc_d        = pc_q;
    pc_en       = 1'b0;
    ir_en       = 1'b0;
    mem_addr_o  = pc_q;
    mem_wdata_o = src_a_i;
    mem_we_o    = 1'b0;
    we0_o       = 1'b0;
    wa0_o       = ir_q[13:10];
    wd0_o       = mem_rdata_i;
    we1_o       = 1'b0;
    wa1_o       = ir_q[8:5];
    wd1_o       = base_i + DW'(1);
    unique case (state_q)
      ST_FETCH: state_d = ST_DECODE;
      ST_DECODE: begin
        ir_en   = 1'b1;
        pc_en   = 1'b1;
        pc_d    = pc_q + DW'(1);
        state_d = ST_EXEC;
      end
      ST_EXEC: begin
        state_d = ST_FETCH;
        if (is_mem) begin
          mem_addr_o = eff_addr;
          if (is_load) begin
            state_d = ST_WBACK;
          end else begin
            mem_we_o = 1'b1;
            we1_o    = post_inc;
          end
        end else if (is_alu) begin
          we0_o = 1'b1;
          wa0_o = ir_q[5:2];
          wd0_o = alu_y_i;
        end else if (is_br && taken) begin
          pc_en = 1'b1;
          pc_d  = pc_q + br_off;
        end
      end
      default: begin
        we0_o   = 1'b1;
        we1_o   = post_inc;
        state_d = ST_FETCH;
      end
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_FETCH;
    else         state_q <= state_d;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     pc_q <= '0;
    else if (pc_en)  pc_q <= pc_d;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     ir_q <= '0;
    else if (ir_en)  ir_q <= mem_rdata_i;
  end

  assign state_o = state_q;
  assign pc_o    = pc_q;
  assign ir_o    = ir_q;
endmodule

// File: rtl/mc16_core.sv
module mc16_core
  import mc16_pkg::*;
#(
  parameter int DW    = 16,
  parameter int NREGS = 16,
  localparam int AW   = $clog2(NREGS)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  output logic [DW-1:0] mem_addr_o,
  output logic [DW-1:0] mem_wdata_o,
  output logic          mem_we_o,
  input  logic [DW-1:0] mem_rdata_i,
  input  logic [AW:0]   dbg_sel_i,
  output logic [DW-1:0] dbg_data_o
);
  logic          rst_n;
  state_e        state;
  logic [DW-1:0] pc, ir;
  logic [DW-1:0] src_a, src_b, base_v, alu_y, dbg_reg;
  logic [AW-1:0] ra, rb, rbase, wa0, wa1;
  logic          we0, we1;
  logic [DW-1:0] wd0, wd1;

  mc16_rst_sync u_rst (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .rst_no (rst_n)
  );

  mc16_ctrl #(.DW(DW)) u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_n),
    .mem_rdata_i (mem_rdata_i),
    .src_a_i     (src_a),
    .src_b_i     (src_b),
    .base_i      (base_v),
    .alu_y_i     (alu_y),
    .state_o     (state),
    .pc_o        (pc),
    .ir_o        (ir),
    .mem_addr_o  (mem_addr_o),
    .mem_wdata_o (mem_wdata_o),
    .mem_we_o    (mem_we_o),
    .ra_o        (ra),
    .rb_o        (rb),
    .rbase_o     (rbase),
    .we0_o       (we0),
    .wa0_o       (wa0),
    .wd0_o       (wd0),
    .we1_o       (we1),
    .wa1_o       (wa1),
    .wd1_o       (wd1)
  );

  mc16_regfile #(.DW(DW), .NREGS(NREGS)) u_rf (
    .clk_i  (clk_i),
    .rst_ni (rst_n),
    .ra_i   (ra),
    .rb_i   (rb),
    .rc_i   (rbase),
    .rdbg_i (dbg_sel_i[AW-1:0]),
    .a_o    (src_a),
    .b_o    (src_b),
    .c_o    (base_v),
    .dbg_o  (dbg_reg),
    .we0_i  (we0),
    .wa0_i  (wa0),
    .wd0_i  (wd0),
    .we1_i  (we1),
    .wa1_i  (wa1),
    .wd1_i  (wd1)
  );

  mc16_alu #(.DW(DW)) u_alu (
    .a_i  (src_a),
    .b_i  (src_b),
    .op_i (aluop_e'(ir[1:0])),
    .y_o  (alu_y)
  );

  assign dbg_data_o = dbg_sel_i[AW] ? pc : dbg_reg;
endmodule

// File: rtl/mc16_chk.sv
module mc16_chk
  import mc16_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic          clk_i,
  input  logic          rst_n,
  input  state_e        state,
  input  logic [DW-1:0] pc,
  input  logic [1:0]    op_cls,
  input  logic [DW-1:0] mem_addr,
  input  logic          mem_we
);
  AST_FETCH_AT_PC: assert property (@(posedge clk_i) disable iff (!rst_n)
    state == ST_FETCH |-> (mem_addr == pc && !mem_we));  // R10

  AST_WE_ONLY_STORE: assert property (@(posedge clk_i) disable iff (!rst_n)
    mem_we |-> (state == ST_EXEC && op_cls == 2'b00));  // R12

  AST_PC_PREINC: assert property (@(posedge clk_i) disable iff (!rst_n)
    (state == ST_EXEC && $past(state) == ST_DECODE) |-> pc == DW'($past(pc) + DW'(1)));  // R2

  AST_PC_HELD: assert property (@(posedge clk_i) disable iff (!rst_n)
    (state == ST_EXEC && op_cls != CLS_BR) |=> $stable(pc));  // R9

  AST_WBACK_AFTER_LOAD: assert property (@(posedge clk_i) disable iff (!rst_n)
    state == ST_WBACK |-> ($past(state) == ST_EXEC && $past(op_cls) == 2'b01));  // R10

  AST_WBACK_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_n)
    state == ST_WBACK |=> state == ST_FETCH);  // R10
endmodule

bind mc16_core mc16_chk #(.DW(DW)) u_chk (
  .clk_i    (clk_i),
  .rst_n    (rst_n),
  .state    (state),
  .pc       (pc),
  .op_cls   (ir[15:14]),
  .mem_addr (mem_addr_o),
  .mem_we   (mem_we_o)
);

// File: tb/test_mc16_core.sv
module test_mc16_core;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [15:0] mem_addr, mem_wdata, mem_rdata, dbg_data;
  logic        mem_we;
  logic [4:0]  dbg_sel = 5'd0;

  int n_chk = 0;
  int n_bad = 0;

  // 125 MHz: 8 time units per period
  always #4 clk = ~clk;

  mc16_core i_mc16_core (
    .clk_i       (clk),
    .rst_ni      (rst_ni),
    .mem_addr_o  (mem_addr),
    .mem_wdata_o (mem_wdata),
    .mem_we_o    (mem_we),
    .mem_rdata_i (mem_rdata),
    .dbg_sel_i   (dbg_sel),
    .dbg_data_o  (dbg_data)
  );

  // Memory model: 1K words, synchronous read and write
  logic [15:0] mem [1024];
  logic        ld_en = 1'b0, clr = 1'b0;
  logic [9:0]  ld_a = '0;
  logic [15:0] ld_d = '0;

  always @(posedge clk) begin
    if (clr) begin
      for (int i = 0; i < 1024; i++) mem[i] <= 16'h0;
    end else if (ld_en) begin
      mem[ld_a] <= ld_d;
    end else if (mem_we) begin
      mem[mem_addr[9:0]] <= mem_wdata;
    end
    mem_rdata <= mem[mem_addr[9:0]];
  end

  // Instruction encoders
  function automatic logic [15:0] i_alu(input logic [3:0] s1, s2, d, input logic [1:0] op);
    return {2'b10, s1, s2, d, op};
  endfunction
  function automatic logic [15:0] i_ld(input logic [3:0] r, input logic [9:0] opd);
    return {2'b01, r, opd};
  endfunction
  function automatic logic [15:0] i_st(input logic [3:0] r, input logic [9:0] opd);
    return {2'b00, r, opd};
  endfunction
  function automatic logic [15:0] i_br(input logic [3:0] a, b, input logic [5:0] off);
    return {2'b11, a, b, off};
  endfunction
  function automatic logic [9:0] o_abs(input logic [8:0] a);
    return {1'b1, a};
  endfunction
  function automatic logic [9:0] o_rel(input logic [3:0] b, input logic [3:0] d, input logic m);
    return {1'b0, b, d, m};
  endfunction
  localparam logic [15:0] HALT = {2'b11, 4'd0, 4'd0, 6'h3F};

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic put(input int a, input logic [15:0] d);
    ld_en = 1'b1; ld_a = 10'(a); ld_d = d;
    @(negedge clk);
    ld_en = 1'b0;
  endtask

  task automatic new_prog();
    @(negedge clk);
    rst_ni = 1'b0;
    clr = 1'b1;
    @(negedge clk);
    clr = 1'b0;
  endtask

  task automatic go(input int n);
    rst_ni = 1'b1;
    repeat (n) @(negedge clk);
  endtask

  task automatic rd(input int idx, output logic [15:0] v);
    dbg_sel = 5'(idx);
    #1;
    v = dbg_data;
  endtask

  // ALU vector table: {opcode, source1, source2, expected}
  localparam int NV = 7;
  localparam logic [49:0] VEC [NV] = '{
    {2'b00, 16'hFFFF, 16'h0F0F, 16'h0F0F},
    {2'b10, 16'hFFFF, 16'h0002, 16'h0001},
    {2'b10, 16'h7FFF, 16'h0001, 16'h8000},
    {2'b01, 16'h0003, 16'h0005, 16'hFFFE},
    {2'b01, 16'h1234, 16'h0234, 16'h1000},
    {2'b11, 16'h0001, 16'h0013, 16'h0008},
    {2'b11, 16'h8001, 16'h000F, 16'h8000}
  };

  logic [15:0] v, v2;
  int          t_chg [8];
  logic [15:0] p_chg [8];

  initial begin
    // Vector loop: R3, R4 (ALU), R5 and R8 (absolute load/store)
    for (int k = 0; k < NV; k++) begin
      new_prog();
      put(0, i_ld(4'd1, o_abs(9'h100)));
      put(1, i_ld(4'd2, o_abs(9'h101)));
      put(2, i_alu(4'd1, 4'd2, 4'd3, VEC[k][49:48]));
      put(3, i_st(4'd3, o_abs(9'h102)));
      put(4, HALT);
      put(16'h100, VEC[k][47:32]);
      put(16'h101, VEC[k][31:16]);
      go(40);
      rd(3, v);
      chk(VEC[k][49:48] == 2'b11 ? "R4 shift result" : "R3 alu result", v, VEC[k][15:0]);
      chk("R5 R8 R12 stored result", mem[16'h102], VEC[k][15:0]);
    end

    // R1: reset clears registers and PC, no write, fetch from 0
    @(negedge clk);
    rst_ni = 1'b0;
    repeat (3) @(negedge clk);
    for (int r = 0; r < 16; r++) begin
      rd(r, v);
      chk("R1 register cleared", v, 16'h0);
    end
    rd(16, v);
    chk("R1 pc cleared", v, 16'h0);
    chk("R1 fetch address", mem_addr, 16'h0);
    chk("R1 no write in reset", {15'h0, mem_we}, 16'h0);

    // Register-relative modes: R6, R7
    new_prog();
    put(0, i_ld(4'd5, o_abs(9'h1F0)));
    put(1, i_ld(4'd6, o_rel(4'd5, 4'hF, 1'b0)));
    put(2, i_ld(4'd7, o_rel(4'd5, 4'h0, 1'b1)));
    put(3, i_st(4'd7, o_rel(4'd5, 4'h2, 1'b1)));
    put(4, i_ld(4'd5, o_rel(4'd5, 4'hF, 1'b1)));
    put(5, i_st(4'd6, o_rel(4'd5, 4'h1, 1'b0)));
    put(6, HALT);
    put(16'h1F0, 16'h0200);
    put(16'h1FF, 16'h5555);
    put(16'h200, 16'hAAAA);
    put(16'h201, 16'h1111);
    go(50);
    rd(6, v);
    chk("R6 negative displacement load", v, 16'h5555);
    rd(7, v);
    chk("R7 post-increment load data", v, 16'hAAAA);
    chk("R7 store after post-increment base", mem[16'h203], 16'hAAAA);
    rd(5, v);
    chk("R7 load into own base ends at base+1", v, 16'h0203);
    chk("R6 mode 0 leaves base unchanged", mem[16'h204], 16'h5555);

    // Branches: R9 unsigned compare, equal taken, not taken
    new_prog();
    put(0, i_ld(4'd1, o_abs(9'h100)));
    put(1, i_ld(4'd2, o_abs(9'h101)));
    put(2, i_br(4'd1, 4'd2, 6'd2));
    put(3, i_alu(4'd1, 4'd1, 4'd3, 2'b10));
    put(4, i_br(4'd2, 4'd1, 6'd2));
    put(5, i_alu(4'd1, 4'd1, 4'd4, 2'b10));
    put(6, i_alu(4'd1, 4'd1, 4'd4, 2'b10));
    put(7, i_br(4'd1, 4'd1, 6'd2));
    put(8, i_alu(4'd1, 4'd1, 4'd5, 2'b10));
    put(9, i_alu(4'd1, 4'd1, 4'd5, 2'b10));
    put(10, i_alu(4'd1, 4'd2, 4'd6, 2'b00));
    put(11, HALT);
    put(16'h100, 16'h0005);
    put(16'h101, 16'hFFFF);
    go(60);
    rd(3, v);
    chk("R9 5 >= FFFF unsigned not taken", v, 16'h000A);
    rd(4, v);
    chk("R9 taken branch skips", v, 16'h0000);
    rd(5, v);
    chk("R9 equal operands taken", v, 16'h0000);
    rd(6, v);
    chk("R2 R9 branch target reached", v, 16'h0005);

    // Backward branch loop: R2, R9 negative offset
    new_prog();
    put(0, i_ld(4'd1, o_abs(9'h100)));
    put(1, i_ld(4'd2, o_abs(9'h101)));
    put(2, i_alu(4'd1, 4'd2, 4'd1, 2'b01));
    put(3, i_alu(4'd3, 4'd2, 4'd3, 2'b10));
    put(4, i_br(4'd1, 4'd2, 6'h3D));
    put(5, HALT);
    put(16'h100, 16'h0003);
    put(16'h101, 16'h0001);
    go(80);
    rd(1, v);
    chk("R9 loop counter final", v, 16'h0000);
    rd(3, v);
    chk("R2 backward branch iterations", v, 16'h0003);
    rd(16, v);
    rd(31, v2);
    chk("R11 both pc selects agree", v2, v);

    // Timing: R10 cycle counts observed on the PC, R2 self-branch
    new_prog();
    put(0, i_alu(4'd0, 4'd0, 4'd1, 2'b10));
    put(1, i_alu(4'd0, 4'd0, 4'd1, 2'b10));
    put(2, i_ld(4'd2, o_abs(9'h100)));
    put(3, i_st(4'd2, o_abs(9'h101)));
    put(4, HALT);
    put(16'h100, 16'hBEEF);
    dbg_sel = 5'd16;
    rst_ni = 1'b1;
    begin
      int          n = 0;
      logic [15:0] prev = 16'h0;
      for (int c = 0; c < 60; c++) begin
        @(negedge clk);
        #1;
        if (dbg_data !== prev && n < 8) begin
          t_chg[n] = c;
          p_chg[n] = dbg_data;
          n++;
        end
        prev = dbg_data;
      end
      chk("R10 pc change count", 16'(n), 16'd8);
    end
    chk("R2 first pc value", p_chg[0], 16'h0001);
    chk("R10 alu takes 3", 16'(t_chg[1] - t_chg[0]), 16'd3);
    chk("R10 alu takes 3 again", 16'(t_chg[2] - t_chg[1]), 16'd3);
    chk("R10 load takes 4", 16'(t_chg[3] - t_chg[2]), 16'd4);
    chk("R10 store takes 3", 16'(t_chg[4] - t_chg[3]), 16'd3);
    chk("R2 pc after halt decode", p_chg[4], 16'h0005);
    chk("R2 self-branch target", p_chg[5], 16'h0004);
    chk("R10 branch acts 1 after decode", 16'(t_chg[5] - t_chg[4]), 16'd1);
    chk("R10 refetch then decode", 16'(t_chg[6] - t_chg[5]), 16'd2);
    chk("R12 store of loaded word", mem[16'h101], 16'hBEEF);
    rd(2, v);
    chk("R11 debug register read", v, 16'hBEEF);

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule